// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is a serial master that shifts a parallel word out on a data line and shifts the same number of bits back in. One word is 1 to 32 bits long. A configuration word controls the serial clock divider, clock idle level and sampling edge, bit order, two-wire or three-wire data mode, word length and the chip-select pattern. The configuration also sets whether chip select is released after the current word or held so that the next word continues the same transaction.

The host waits for `writable_o`, writes configuration with `cfg_we_i`, and starts a word with a one-cycle `load_i`. When the word is finished, `readable_o` pulses for one cycle and `rdata_o` holds the received bits. Every pin has an output-enable. When the release bit is set, all enables drop and the pins float.

Configuration word fields:
- bit 0: release
- bit 1: last
- bit 2: select invert
- bit 3: clock idle level (cpol)
- bit 4: phase (cpha)
- bit 5: lsb-first
- bit 6: three-wire
- bits [11:7]: length minus one
- bits [19:12]: divider
- bits [27:20]: select pattern

Top module: `spi_shift_master`

## Requirements
- R1: After reset, release and last are 1 and every other configuration field is 0. So `writable_o`=1, `readable_o`=0, `cs_o`=0, `sclk_o`=0, all enables are 0, and a word loaded without any configuration write shifts 1 bit and then releases chip select.
- R2: Every bit takes divider+2 cycles. Consecutive leading serial clock edges are exactly divider+2 cycles apart. `readable_o` is seen n*(divider+2)+1 cycles after the cycle that carries `load_i`, where n = length+1.
- R3: A `load_i` accepted while `writable_o`=1 drops `writable_o` until the word ends. `readable_o` is a single-cycle pulse and is never high together with `writable_o`. A word makes exactly 2n serial clock edges.
- R4: `sclk_o` idles at cpol. The sampling edge is rising when cpol equals cpha and falling otherwise. `mosi_o` never changes in a cycle that shows a sampling edge.
- R5: With lsb-first=0, bits leave from bit 31 downward, and received bits enter at bit 0 while the word moves left. With the return line tied to `mosi_o`, `rdata_o` is the loaded word rotated left by n.
- R6: With lsb-first=1, bits leave from bit 0 upward, and received bits enter at bit 31 while the word moves right. With loopback, `rdata_o` is the loaded word rotated right by n.
- R7: While a transaction is open, `cs_o` equals the select pattern XOR the invert bit replicated. When closed, it equals the invert bit replicated. Outside configuration writes, no `cs_o` change falls in the same cycle as a `sclk_o` change.
- R8: With last=1, chip select closes after the word. With last=0, it stays open for the next word.
- R9: With three-wire=1, received bits come from `mosi_i` and `miso_i` is ignored. `mosi_oe_o` is 0 exactly in each cycle whose closing edge captures a bit and raises the sampling edge, and 1 otherwise.
- R10: With release=1, `sclk_oe_o`, `mosi_oe_o` and `cs_oe_o` are all 0. With release=0 and no capture in progress, all three are 1.
- R11: A configuration write is ignored when `writable_o`=0, and also when it comes in the same cycle as `load_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 28 | Configuration word |
| load_i | input | 1 | Start a word |
| data_i | input | 32 | Word to send |
| writable_o | output | 1 | Engine idle, accepts load or configuration |
| readable_o | output | 1 | One-cycle pulse, received word valid |
| rdata_o | output | 32 | Received word |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Data out enable |
| mosi_i | input | 1 | Data line readback, used in three-wire mode |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 8 | Chip selects |
| cs_oe_o | output | 1 | Chip select output enable |

## Verification
A host configuration write can land in the same cycle as a word start, or while a word is in flight. Both cases are provoked deliberately: one word is started with a conflicting write during its transfer, and another has a write raised in the very cycle of its `load_i`. The result is judged at the pins: the received word must still match the old length, and the held chip-select pattern must be unchanged afterwards. The sampling edge and a data change could also coincide; a per-cycle monitor rejects any `mosi_o` change on a sampling edge across all four clock modes, both bit orders, both wire modes and every length.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BITS,
    ST_HOLD
  } spim_state_e;
endpackage

// File: rtl/spim_clkgen.sv
// Half-period down counter; lead half = div/2+1, trail half = div+1-div/2 cycles.
module spim_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DIVW-1:0] div_i,
  input  logic            arm_i,
  input  logic            half_i,
  input  logic            en_i,
  output logic            tick_o
);
  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] dur;

  always_comb dur = half_i ? (div_i - (div_i >> 1)) : (div_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (arm_i)                   cnt_q <= dur;
    else if (en_i && cnt_q != '0)     cnt_q <= cnt_q - DIVW'(1);
  end

  assign tick_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/spim_shreg.sv
module spim_shreg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          lsb_i,
  input  logic          shift_i,
  input  logic          rx_i,
  output logic [DW-1:0] q_o,
  output logic          out_bit_o,
  output logic          first_bit_o
);
  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (load_i)   q_q <= data_i;
    else if (shift_i)  q_q <= lsb_i ? {rx_i, q_q[DW-1:1]} : {q_q[DW-2:0], rx_i};
  end

  assign q_o         = q_q;
  assign out_bit_o   = lsb_i ? q_q[0] : q_q[DW-1];
  assign first_bit_o = lsb_i ? data_i[0] : data_i[DW-1];
endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_pkg::*;
#(
  parameter int LENW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            cpha_i,
  input  logic            last_i,
  input  logic [LENW-1:0] len_i,
  input  logic            tick_i,
  input  logic            out_bit_i,
  input  logic            first_bit_i,
  output logic            writable_o,
  output logic            readable_o,
  output logic            arm_o,
  output logic            half_o,
  output logic            en_o,
  output logic            smp_o,
  output logic            start_o,
  output logic            sclk_act_o,
  output logic            cs_act_o,
  output logic            mosi_o
);
  spim_state_e     state_q;
  logic            hf_q, sclk_q, cs_q, mosi_q, rdy_q;
  logic [LENW-1:0] bcnt_q;
  logic            start, edge_now, oedge;

  assign start    = load_i && (state_q == ST_IDLE);
  assign edge_now = (state_q == ST_BITS) && tick_i;
  // leading edge samples when cpha=0, trailing edge samples when cpha=1
  assign smp_o    = edge_now && (hf_q == cpha_i);
  assign oedge    = edge_now && (hf_q != cpha_i);
  assign en_o     = (state_q != ST_IDLE);

  always_comb begin
    arm_o  = 1'b0;
    half_o = 1'b0;
    if (start) begin
      arm_o = 1'b1;
    end else if (edge_now) begin
      arm_o  = 1'b1;
      half_o = !hf_q;
    end else if (state_q == ST_BITS || state_q == ST_HOLD) begin
      arm_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hf_q    <= 1'b0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
      mosi_q  <= 1'b0;
      rdy_q   <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      rdy_q <= 1'b0;
      if (oedge) mosi_q <= out_bit_i;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_BITS;
            hf_q    <= 1'b0;
            bcnt_q  <= len_i;
            cs_q    <= 1'b1;
            if (!cpha_i) mosi_q <= first_bit_i;
          end
        end
        ST_BITS: begin
          if (tick_i) begin
            if (!hf_q) begin
              hf_q   <= 1'b1;
              sclk_q <= 1'b1;
            end else begin
              hf_q   <= 1'b0;
              sclk_q <= 1'b0;
              if (bcnt_q == '0) begin
                state_q <= ST_HOLD;
                rdy_q   <= 1'b1;
              end else begin
                bcnt_q <= bcnt_q - LENW'(1);
              end
            end
          end
        end
        ST_HOLD: begin
          if (tick_i) begin
            state_q <= ST_IDLE;
            if (last_i) cs_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign writable_o = (state_q == ST_IDLE);
  assign readable_o = rdy_q;
  assign start_o    = start;
  assign sclk_act_o = sclk_q;
  assign cs_act_o   = cs_q;
  assign mosi_o     = mosi_q;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter  int DW   = 32,
  parameter  int DIVW = 8,
  parameter  int NCS  = 8,
  localparam int LENW = $clog2(DW),
  localparam int CFGW = 7 + LENW + DIVW + NCS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [CFGW-1:0] cfg_i,
  input  logic            load_i,
  input  logic [DW-1:0]   data_i,
  output logic            writable_o,
  output logic            readable_o,
  output logic [DW-1:0]   rdata_o,
  output logic            sclk_o,
  output logic            sclk_oe_o,
  output logic            mosi_o,
  output logic            mosi_oe_o,
  input  logic            mosi_i,
  input  logic            miso_i,
  output logic [NCS-1:0]  cs_o,
  output logic            cs_oe_o
);
  localparam int B_REL  = 0;
  localparam int B_LAST = 1;
  localparam int B_INV  = 2;
  localparam int B_CPOL = 3;
  localparam int B_CPHA = 4;
  localparam int B_LSB  = 5;
  localparam int B_3W   = 6;
  localparam int O_LEN  = 7;
  localparam int O_DIV  = O_LEN + LENW;
  localparam int O_SEL  = O_DIV + DIVW;
  localparam logic [CFGW-1:0] CFG_RST = CFGW'((1 << B_REL) | (1 << B_LAST));

  logic [CFGW-1:0] cfg_q;
  logic            rel, last, inv, cpol, cpha, lsb, tw;
  logic [LENW-1:0] len;
  logic [DIVW-1:0] div;
  logic [NCS-1:0]  sel;

  logic tick, arm, half, en, smp, start, sclk_act, cs_act, mosi_q;
  logic out_bit, first_bit, rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cfg_q <= CFG_RST;
    else if (cfg_we_i && writable_o && !load_i)     cfg_q <= cfg_i;
  end

  assign rel  = cfg_q[B_REL];
  assign last = cfg_q[B_LAST];
  assign inv  = cfg_q[B_INV];
  assign cpol = cfg_q[B_CPOL];
  assign cpha = cfg_q[B_CPHA];
  assign lsb  = cfg_q[B_LSB];
  assign tw   = cfg_q[B_3W];
  assign len  = cfg_q[O_LEN +: LENW];
  assign div  = cfg_q[O_DIV +: DIVW];
  assign sel  = cfg_q[O_SEL +: NCS];

  assign rx = tw ? mosi_i : miso_i;

  spim_clkgen #(.DIVW(DIVW)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div),
    .arm_i  (arm),
    .half_i (half),
    .en_i   (en),
    .tick_o (tick)
  );

  spim_shreg #(.DW(DW)) i_shreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .data_i      (data_i),
    .lsb_i       (lsb),
    .shift_i     (smp),
    .rx_i        (rx),
    .q_o         (rdata_o),
    .out_bit_o   (out_bit),
    .first_bit_o (first_bit)
  );

  spim_seq #(.LENW(LENW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .cpha_i      (cpha),
    .last_i      (last),
    .len_i       (len),
    .tick_i      (tick),
    .out_bit_i   (out_bit),
    .first_bit_i (first_bit),
    .writable_o  (writable_o),
    .readable_o  (readable_o),
    .arm_o       (arm),
    .half_o      (half),
    .en_o        (en),
    .smp_o       (smp),
    .start_o     (start),
    .sclk_act_o  (sclk_act),
    .cs_act_o    (cs_act),
    .mosi_o      (mosi_q)
  );

  assign sclk_o    = sclk_act ^ cpol;
  assign sclk_oe_o = !rel;
  assign mosi_o    = mosi_q;
  // three-wire turnaround: driver off in the capture cycle
  assign mosi_oe_o = !rel && !(tw && smp);
  assign cs_oe_o   = !rel;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_o[g] = (cs_act & sel[g]) ^ inv;
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int NCS = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_we_i,
  input logic           load_i,
  input logic           writable_o,
  input logic           readable_o,
  input logic           sclk_o,
  input logic           sclk_oe_o,
  input logic           mosi_oe_o,
  input logic [NCS-1:0] cs_o
);
  a_r3_load_drops_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && writable_o |=> !writable_o);

  a_r3_readable_not_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    readable_o |-> !writable_o);

  a_r3_readable_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    readable_o |=> !readable_o);

  a_r7_no_cs_sclk_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != $past(cs_o)) && !$past(cfg_we_i) |-> sclk_o == $past(sclk_o));

  a_r4_idle_sclk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    writable_o && $past(writable_o) && !$past(cfg_we_i) |-> sclk_o == $past(sclk_o));

  a_r9_release_before_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mosi_oe_o && sclk_oe_o |=> sclk_o != $past(sclk_o));
endmodule

bind spi_shift_master spim_checker #(.NCS(NCS)) i_spim_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .load_i     (load_i),
  .writable_o (writable_o),
  .readable_o (readable_o),
  .sclk_o     (sclk_o),
  .sclk_oe_o  (sclk_oe_o),
  .mosi_oe_o  (mosi_oe_o),
  .cs_o       (cs_o)
);

// File: tb/test_spi_shift_master.sv
module test_spi_shift_master;
  localparam int CFGW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            cfg_we = 1'b0;
  logic [CFGW-1:0] cfg_w = '0;
  logic            load = 1'b0;
  logic [31:0]     data_w = '0;
  logic            writable_o, readable_o, sclk_o, sclk_oe_o, mosi_o, mosi_oe_o, cs_oe_o;
  logic [31:0]     rdata_o;
  logic [7:0]      cs_o;
  logic            mosi_line, miso;

  assign miso      = mosi_o;
  assign mosi_line = mosi_oe_o ? mosi_o : ~mosi_o;

  spi_shift_master i_spi_shift_master (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_i      (cfg_w),
    .load_i     (load),
    .data_i     (data_w),
    .writable_o (writable_o),
    .readable_o (readable_o),
    .rdata_o    (rdata_o),
    .sclk_o     (sclk_o),
    .sclk_oe_o  (sclk_oe_o),
    .mosi_o     (mosi_o),
    .mosi_oe_o  (mosi_oe_o),
    .mosi_i     (mosi_line),
    .miso_i     (miso),
    .cs_o       (cs_o),
    .cs_oe_o    (cs_oe_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  bit   mon_en = 1'b1;
  logic cur_cpol = 1'b0, cur_cpha = 1'b0;
  int   cur_div = 0;
  int   edge_cnt = 0, edge_err = 0, cyc = 0, last_lead = 0;
  bit   have_lead = 1'b0;
  logic p_sclk = 1'b0, p_mosi = 1'b0;
  logic [7:0] p_cs = '0;
  int   wd = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_en && rst_n) begin
      if (sclk_o != p_sclk) begin
        edge_cnt++;
        if (cs_o != p_cs) edge_err++;                                       // R7
        if (sclk_o == (cur_cpol == cur_cpha) && mosi_o != p_mosi) edge_err++; // R4
        if (sclk_o != cur_cpol) begin
          if (have_lead && (cyc - last_lead) != cur_div + 2) edge_err++;     // R2
          last_lead = cyc;
          have_lead = 1'b1;
        end
      end
    end
    p_sclk = sclk_o;
    p_mosi = mosi_o;
    p_cs   = cs_o;
  end

  task automatic show_summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", wd, 190000);
      show_summary();
      $finish;
    end
  end

  function automatic logic [CFGW-1:0] mk_cfg(input bit rel, input bit lst, input bit inv,
      input bit cpol, input bit cpha, input bit lsb, input bit tw,
      input int n, input int div, input logic [7:0] sel);
    logic [4:0] len;
    logic [7:0] dv;
    len = 5'(n - 1);
    dv  = 8'(div);
    return {sel, dv, len, tw, lsb, cpha, cpol, inv, lst, rel};
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] d, input int n, input bit lsb, input bit tw);
    logic [63:0] dd;
    logic [31:0] r, m;
    dd = {d, d};
    if (lsb) begin
      dd = dd >> n;
      r  = dd[31:0];
      m  = ~(32'hFFFF_FFFF >> n);
    end else begin
      dd = dd << n;
      r  = dd[63:32];
      m  = (32'd1 << n) - 32'd1;
    end
    if (tw) r = r ^ m;
    return r;
  endfunction

  task automatic set_cfg(input logic [CFGW-1:0] c);
    mon_en = 1'b0;
    @(negedge clk);
    cfg_w  = c;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we   = 1'b0;
    cur_cpol = c[3];
    cur_cpha = c[4];
    cur_div  = int'(c[19:12]);
    @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic run_word(input logic [31:0] d, input int n, input bit lsb, input bit tw,
      input bit lst, input logic [7:0] sel, input bit inv);
    int lat;
    logic [31:0] e;
    string tag;
    @(negedge clk);
    edge_cnt  = 0;
    edge_err  = 0;
    have_lead = 1'b0;
    data_w = d;
    load   = 1'b1;
    @(negedge clk);
    load = 1'b0;
    lat  = 1;
    chk(!writable_o, "R3 busy", 64'(writable_o), 64'd0);
    while (!readable_o) begin
      @(negedge clk);
      lat++;
    end
    e   = exp_rx(d, n, lsb, tw);
    tag = tw ? "R9 rx" : (lsb ? "R6 rx" : "R5 rx");
    chk(rdata_o == e, tag, 64'(rdata_o), 64'(e));
    chk(lat == n * (cur_div + 2) + 1, "R2 latency", 64'(lat), 64'(n * (cur_div + 2) + 1));
    chk(cs_o == (sel ^ {8{inv}}), "R7 cs open", 64'(cs_o), 64'(sel ^ {8{inv}}));
    @(negedge clk);
    chk(!readable_o, "R3 pulse", 64'(readable_o), 64'd0);
    while (!writable_o) @(negedge clk);
    chk(edge_cnt == 2 * n, "R3 edges", 64'(edge_cnt), 64'(2 * n));
    chk(edge_err == 0, "R4 R7 edge rules", 64'(edge_err), 64'd0);
    chk(sclk_o == cur_cpol, "R4 idle", 64'(sclk_o), 64'(cur_cpol));
    if (lst) chk(cs_o == {8{inv}}, "R8 close", 64'(cs_o), 64'({8{inv}}));
    else     chk(cs_o == (sel ^ {8{inv}}), "R8 hold", 64'(cs_o), 64'(sel ^ {8{inv}}));
  endtask

  initial begin
    logic [31:0] d;
    int k;
    d = 32'h1234_5678;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sclk_oe_o && !mosi_oe_o && !cs_oe_o, "R10 reset release", {61'd0, sclk_oe_o, mosi_oe_o, cs_oe_o}, 64'd0);
    chk(writable_o && !readable_o, "R1 handshake", {62'd0, writable_o, readable_o}, 64'd2);
    chk(cs_o == 8'h00 && sclk_o == 1'b0, "R1 pins", {55'd0, cs_o, sclk_o}, 64'd0);
    // R1: defaults give 1 bit, divider 0, msb first, last=1
    run_word(32'hC000_0001, 1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);

    for (int mode = 0; mode < 16; mode++) begin
      for (int dv = 0; dv < 2; dv++) begin
        for (int n = 1; n <= 32; n++) begin
          bit cp, ph, lsb, tw, lst, inv;
          logic [7:0] sel;
          cp  = mode[0];
          ph  = mode[1];
          lsb = mode[2];
          tw  = mode[3];
          lst = k[1];
          inv = k[0];
          sel = 8'(k * 37 + 1);
          set_cfg(mk_cfg(1'b0, lst, inv, cp, ph, lsb, tw, n, dv * 3, sel));
          d = d * 32'd1664525 + 32'd1013904223;
          run_word(d, n, lsb, tw, lst, sel, inv);
          k++;
        end
      end
    end

    for (int dv = 0; dv < 8; dv++) begin
      set_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5, dv, 8'h5A));
      d = d * 32'd1664525 + 32'd1013904223;
      run_word(d, 5, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0);
    end

    // R11: write during busy is dropped
    set_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8, 1, 8'h3C));
    @(negedge clk);
    data_w = 32'hA5F0_0F5A;
    load   = 1'b1;
    @(negedge clk);
    load   = 1'b0;
    cfg_w  = mk_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32, 1, 8'hFF);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    while (!readable_o) @(negedge clk);
    chk(rdata_o == exp_rx(32'hA5F0_0F5A, 8, 1'b0, 1'b0), "R11 busy write rx", 64'(rdata_o),
        64'(exp_rx(32'hA5F0_0F5A, 8, 1'b0, 1'b0)));
    while (!writable_o) @(negedge clk);
    chk(cs_o == 8'h3C, "R11 busy write cs", 64'(cs_o), 64'h3C);

    // R11: write in the load cycle is dropped
    @(negedge clk);
    data_w = 32'h0F1E_2D3C;
    load   = 1'b1;
    cfg_w  = mk_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32, 1, 8'h81);
    cfg_we = 1'b1;
    @(negedge clk);
    load   = 1'b0;
    cfg_we = 1'b0;
    while (!readable_o) @(negedge clk);
    chk(rdata_o == exp_rx(32'h0F1E_2D3C, 8, 1'b0, 1'b0), "R11 same-cycle rx", 64'(rdata_o),
        64'(exp_rx(32'h0F1E_2D3C, 8, 1'b0, 1'b0)));
    while (!writable_o) @(negedge clk);
    chk(cs_o == 8'h3C, "R11 same-cycle cs", 64'(cs_o), 64'h3C);

    // R10: release floats every pin, clearing it drives them again
    set_cfg(mk_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8, 1, 8'h3C));
    chk(!sclk_oe_o && !mosi_oe_o && !cs_oe_o, "R10 released", {61'd0, sclk_oe_o, mosi_oe_o, cs_oe_o}, 64'd0);
    set_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8, 1, 8'h3C));
    chk(sclk_oe_o && mosi_oe_o && cs_oe_o, "R10 driven", {61'd0, sclk_oe_o, mosi_oe_o, cs_oe_o}, 64'd7);

    show_summary();
    $finish;
  end
endmodule